// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 16-bit virtual address into a 16-bit physical address. Pages are 256 bytes. The upper byte of the address selects a page and the lower byte is the offset inside it. For each ordinary request the block reads a two-byte page entry from one of two tables in memory. Two configuration inputs give the base address of each table: one table serves unprivileged (user) requests and the other serves privileged (kernel) requests. The first byte of an entry holds flags and the second holds the physical page number. The block checks the flags against the kind of access and reports either a page fault or a copy-on-write fault.

Two cases need no table read. When mapping is turned off, each address passes straight through. When the kernel-window enable is set, virtual addresses 0xC000 to 0xEFFF map linearly onto the 12 KiB of physical memory that starts at 0x0800. A request is accepted only when the unit is idle. The result is held until the requester acknowledges it. There is no entry cache, and the unit never writes the tables.

Top module: `page_xlate`

## Requirements
- R1: The low 8 bits of `rsp_paddr` equal the low 8 bits of the accepted virtual address. On a table walk the upper byte of `rsp_paddr` is the page byte of the entry.
- R2: A table walk reads the entry at `base + 2*page` for the flags and at `base + 2*page + 1` for the page byte, with 16-bit wrap. The two reads fall on the two cycles right after acceptance. `base` is `user_base` when `req_user` is 1 and `kern_base` when it is 0. Read data arrives one cycle after each read.
- R3: The flag bits are: bit0 valid, bit1 cacheable, bit2 read-only, bit3 copy-on-write, bit4 executable. Bits 7:5 are ignored. On a walk, `rsp_cacheable` equals bit1.
- R4: A walk whose entry has the valid bit clear reports `rsp_pagef` = 1 and `rsp_cow` = 0, whatever the access kind.
- R5: Access kind encoding is 00 read, 01 write, 10 fetch, 11 read. `rsp_pagef` is raised in two cases: a fetch of a valid entry without the executable bit, and a write to a valid entry that has read-only set and copy-on-write clear. A read of a valid entry raises no fault.
- R6: A write to a valid entry with copy-on-write set reports `rsp_cow` = 1 and `rsp_pagef` = 0, even when read-only is also set. `rsp_cow` and `rsp_pagef` are never high together.
- R7: With `map_en` low, `rsp_paddr` equals the virtual address, with no fault, `rsp_cacheable` = 0 and no memory read.
- R8: With `map_en` and `kprot` high, a virtual address in 0xC000..0xEFFF maps to the address minus 0xB800, with `rsp_cacheable` = 1, no fault and no memory read. Addresses outside that range, or any address with `kprot` low, take a table walk.
- R9: `req_ready` is high only when idle. A response stays valid and unchanged until `rsp_ack` is sampled high, and the unit returns to idle on that edge.
- R10: While `rst` is high on a clock edge, the unit goes idle: `req_ready` 1, `rsp_valid` 0, `mem_rd_en` 0.
- R11: A request that needs no walk gives `rsp_valid` on the edge that accepts it. A walk gives `rsp_valid` three edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| map_en | input | 1 | Translation enable |
| kprot | input | 1 | Kernel linear window enable |
| user_base | input | 16 | User table base address |
| kern_base | input | 16 | Kernel table base address |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken |
| req_vaddr | input | 16 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| req_user | input | 1 | 1 selects user table, 0 kernel table |
| mem_rd_en | output | 1 | Entry read strobe |
| mem_rd_addr | output | 16 | Entry byte address |
| mem_rd_data | input | 8 | Entry byte, one cycle after the strobe |
| rsp_valid | output | 1 | Result valid |
| rsp_ack | input | 1 | Result consumed |
| rsp_paddr | output | 16 | Physical address |
| rsp_cacheable | output | 1 | Cacheable attribute |
| rsp_pagef | output | 1 | Page fault |
| rsp_cow | output | 1 | Copy-on-write fault |

## Verification
A request that needs no walk shows `rsp_valid` right after the edge that accepts it. A walk shows its reads in the first and second cycles after acceptance and `rsp_valid` after the third edge. The result then stays until the edge that samples `rsp_ack`, and `req_ready` returns on that same edge. The bench keeps a cycle counter per request that follows this schedule. At every falling edge it compares the ready flag, the read strobe and address, the valid flag and, while valid, every result field. An early or late output therefore fails in the cycle it appears.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int AW = 16,
  parameter int OFS = 8,
  parameter logic [AW-1:0] KWIN_LO = 16'hC000,
  parameter logic [AW-1:0] KWIN_HI = 16'hEFFF,
  parameter logic [AW-1:0] KPHYS = 16'h0800
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          map_en,
  input  logic          kprot,
  input  logic [AW-1:0] user_base,
  input  logic [AW-1:0] kern_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic [1:0]    req_kind,
  input  logic          req_user,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          rsp_valid,
  input  logic          rsp_ack,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_cacheable,
  output logic          rsp_pagef,
  output logic          rsp_cow
);
  localparam int PW = AW - OFS;
  localparam logic [AW-1:0] KSHIFT = KWIN_LO - KPHYS;
  localparam logic [1:0] K_WRITE = 2'b01;
  localparam logic [1:0] K_FETCH = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_FIN, S_RESP} st_t;
  st_t st;

  logic [AW-1:0]  ea;
  logic [OFS-1:0] off;
  logic [1:0]     kind;
  logic [4:0]     flg;

  wire accept = req_valid && (st == S_IDLE);
  wire in_win = kprot && (req_vaddr >= KWIN_LO) && (req_vaddr <= KWIN_HI);
  wire direct = !map_en || in_win;
  wire [AW-1:0] base = req_user ? user_base : kern_base;
  wire [AW-1:0] entry = base + {{(AW-PW-1){1'b0}}, req_vaddr[AW-1:OFS], 1'b0};

  assign req_ready   = (st == S_IDLE);
  assign rsp_valid   = (st == S_RESP);
  assign mem_rd_en   = (st == S_RD0) || (st == S_RD1);
  assign mem_rd_addr = (st == S_RD1) ? ea + AW'(1) : ea;

  wire f_v   = flg[0];
  wire f_ro  = flg[2];
  wire f_cw  = flg[3];
  wire f_x   = flg[4];
  wire is_wr = (kind == K_WRITE);
  wire is_fx = (kind == K_FETCH);
  wire pf_n  = !f_v || (is_fx && !f_x) || (is_wr && f_ro && !f_cw);
  wire cw_n  = f_v && is_wr && f_cw;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      ea <= '0;
      off <= '0;
      kind <= '0;
      flg <= '0;
      rsp_paddr <= '0;
      rsp_cacheable <= 1'b0;
      rsp_pagef <= 1'b0;
      rsp_cow <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          off  <= req_vaddr[OFS-1:0];
          kind <= req_kind;
          ea   <= entry;
          if (direct) begin
            rsp_paddr     <= map_en ? req_vaddr - KSHIFT : req_vaddr;
            rsp_cacheable <= map_en;
            rsp_pagef     <= 1'b0;
            rsp_cow       <= 1'b0;
            st <= S_RESP;
          end else begin
            st <= S_RD0;
          end
        end
        S_RD0: st <= S_RD1;
        S_RD1: begin
          flg <= mem_rd_data[4:0];
          st  <= S_FIN;
        end
        S_FIN: begin
          rsp_paddr     <= {mem_rd_data[PW-1:0], off};
          rsp_cacheable <= flg[1];
          rsp_pagef     <= pf_n;
          rsp_cow       <= cw_n;
          st <= S_RESP;
        end
        S_RESP: if (rsp_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          map_en,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_vaddr,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr,
  input logic          rsp_valid,
  input logic          rsp_ack,
  input logic [AW-1:0] rsp_paddr,
  input logic          rsp_pagef,
  input logic          rsp_cow
);
  logic [7:0] last_off;
  always_ff @(posedge clk) begin
    if (rst) last_off <= '0;
    else if (req_valid && req_ready) last_off <= req_vaddr[7:0];
  end

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_paddr[7:0] == last_off); // R1
  AST_READ_PAIR: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_en) |=> mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + AW'(1)); // R2
  AST_READ_TWO: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en && $past(mem_rd_en) |=> !mem_rd_en); // R2
  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_pagef && rsp_cow)); // R6
  AST_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !map_en) |=> rsp_valid && !rsp_pagef && !rsp_cow
      && rsp_paddr == $past(req_vaddr)); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_pagef)
      && $stable(rsp_cow)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_rd_en && !rsp_valid); // R9
endmodule

bind page_xlate page_xlate_chk u_chk (
  .clk(clk), .rst(rst), .map_en(map_en), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_paddr(rsp_paddr),
  .rsp_pagef(rsp_pagef), .rsp_cow(rsp_cow)
);

// File: tb/tb_page_xlate.sv
module tb_page_xlate;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1, map_en = 0, kprot = 0;
  logic [15:0] user_base = 16'h4000, kern_base = 16'h6000;
  logic req_valid = 0, req_user = 0, rsp_ack = 0;
  logic [15:0] req_vaddr = 0;
  logic [1:0] req_kind = 0;
  logic req_ready, mem_rd_en, rsp_valid, rsp_cacheable, rsp_pagef, rsp_cow;
  logic [15:0] mem_rd_addr, rsp_paddr;
  logic [7:0] mem_rd_data = 0;

  page_xlate dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  string cur_tag = "R10";
  logic [7:0] tbl [int];

  function automatic logic [7:0] mem_at(logic [15:0] a);
    if (tbl.exists(int'(a))) return tbl[int'(a)];
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic void set_pte(logic [15:0] b, logic [7:0] pg, logic [7:0] f, logic [7:0] pb);
    logic [15:0] a = b + {7'd0, pg, 1'b0};
    tbl[int'(a)] = f;
    tbl[int'(a + 16'd1)] = pb;
  endfunction

  always @(posedge clk) mem_rd_data <= mem_rd_en ? mem_at(mem_rd_addr) : 8'hxx;

  // reference model: counts edges per the schedule in the requirements
  bit started = 0, busy = 0, rv = 0;
  int cnt = 0;
  logic [15:0] e_pa, e_ea;
  bit e_c, e_pf, e_cw;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin busy = 0; rv = 0; cnt = 0; end
    else if (rv) begin if (rsp_ack) begin rv = 0; busy = 0; end end
    else if (cnt > 0) begin cnt--; if (cnt == 0) rv = 1; end
    else if (!busy && req_valid) begin
      logic [7:0] f, pb;
      busy = 1;
      if (!map_en) begin
        e_pa = req_vaddr; e_c = 0; e_pf = 0; e_cw = 0; rv = 1;
      end else if (kprot && req_vaddr >= 16'hC000 && req_vaddr <= 16'hEFFF) begin
        e_pa = req_vaddr - 16'hB800; e_c = 1; e_pf = 0; e_cw = 0; rv = 1;
      end else begin
        e_ea = (req_user ? user_base : kern_base) + {7'd0, req_vaddr[15:8], 1'b0};
        f = mem_at(e_ea); pb = mem_at(e_ea + 16'd1);
        e_pa = {pb, req_vaddr[7:0]};
        e_c = f[1];
        e_pf = !f[0] || (req_kind == 2'b10 && !f[4]) || (req_kind == 2'b01 && f[2] && !f[3]);
        e_cw = f[0] && req_kind == 2'b01 && f[3];
        cnt = 3;
      end
    end
  end

  task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("R9", "req_ready", 16'(req_ready), 16'(!busy));
    chk("R11", "rsp_valid", 16'(rsp_valid), 16'(rv));
    chk("R2", "mem_rd_en", 16'(mem_rd_en), 16'(cnt == 3 || cnt == 2));
    if (cnt == 3) chk("R2", "flags addr", mem_rd_addr, e_ea);
    if (cnt == 2) chk("R2", "page addr", mem_rd_addr, e_ea + 16'd1);
    if (rv && rsp_valid) begin
      chk(cur_tag, "rsp_paddr", rsp_paddr, e_pa);
      chk(cur_tag, "rsp_cacheable", 16'(rsp_cacheable), 16'(e_c));
      chk(cur_tag, "rsp_pagef", 16'(rsp_pagef), 16'(e_pf));
      chk(cur_tag, "rsp_cow", 16'(rsp_cow), 16'(e_cw));
    end
  end

  task automatic xlate(string tag, logic [15:0] va, logic [1:0] k, logic u, int hold = 0);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_tag = tag;
    req_vaddr = va; req_kind = k; req_user = u; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    repeat (hold) @(negedge clk);
    rsp_ack = 1;
    @(negedge clk);
    rsp_ack = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: idle after reset
    chk("R10", "ready in reset", 16'(req_ready), 16'd1);
    chk("R10", "valid in reset", 16'(rsp_valid), 16'd0);
    chk("R10", "rd_en in reset", 16'(mem_rd_en), 16'd0);
    rst = 0;
    // R7: mapping off
    xlate("R7", 16'h0800, 2'b10, 0);
    xlate("R7", 16'hC123, 2'b01, 1);
    // R8: kernel linear window and its edges
    map_en = 1; kprot = 1;
    set_pte(kern_base, 8'hBF, 8'h13, 8'h21);
    set_pte(kern_base, 8'hF0, 8'h03, 8'h22);
    xlate("R8", 16'hC000, 2'b00, 0);
    xlate("R8", 16'hEFFF, 2'b10, 1);
    xlate("R8", 16'hBFFF, 2'b00, 0);
    xlate("R8", 16'hF010, 2'b00, 0);
    kprot = 0;
    set_pte(kern_base, 8'hC0, 8'h01, 8'h33);
    xlate("R8", 16'hC044, 2'b00, 0);
    // R1 R3: valid read, offset kept, cacheable from bit1, reserved bits ignored
    set_pte(kern_base, 8'h12, 8'hE3, 8'h9A);
    xlate("R1", 16'h12AB, 2'b00, 0);
    set_pte(kern_base, 8'h13, 8'hE1, 8'h9B);
    xlate("R3", 16'h13FF, 2'b11, 0);
    // R2: user versus kernel table, base wrap
    set_pte(user_base, 8'h12, 8'h01, 8'h5C);
    xlate("R2", 16'h1200, 2'b00, 1);
    user_base = 16'hFFFE;
    set_pte(user_base, 8'h01, 8'h03, 8'h77);
    xlate("R2", 16'h0155, 2'b00, 1);
    user_base = 16'h4000;
    // R4: invalid entry
    set_pte(user_base, 8'h20, 8'h1E, 8'h10);
    xlate("R4", 16'h2001, 2'b00, 1);
    xlate("R4", 16'h2002, 2'b01, 1);
    // R5: permissions
    set_pte(user_base, 8'h21, 8'h05, 8'h11);
    xlate("R5", 16'h2100, 2'b10, 1);
    xlate("R5", 16'h2101, 2'b01, 1);
    xlate("R5", 16'h2102, 2'b00, 1);
    set_pte(user_base, 8'h22, 8'h11, 8'h12);
    xlate("R5", 16'h2203, 2'b10, 1);
    // R6: copy-on-write
    set_pte(user_base, 8'h23, 8'h0D, 8'h13);
    xlate("R6", 16'h2304, 2'b01, 1);
    set_pte(user_base, 8'h24, 8'h09, 8'h14);
    xlate("R6", 16'h2405, 2'b01, 1);
    xlate("R6", 16'h2406, 2'b10, 1);
    // R9: held response with late ack
    xlate("R9", 16'h2407, 2'b00, 1, 5);
    xlate("R9", 16'h0900, 2'b00, 0, 3);
    // R10: reset in the middle of a walk
    @(negedge clk);
    cur_tag = "R10";
    req_vaddr = 16'h2100; req_kind = 0; req_user = 1; req_valid = 1;
    @(negedge clk);
    req_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R10", "ready after mid reset", 16'(req_ready), 16'd1);
    chk("R10", "rd_en after mid reset", 16'(mem_rd_en), 16'd0);
    // R11: back-to-back mixed latencies
    map_en = 0;
    xlate("R11", 16'h3456, 2'b00, 0);
    map_en = 1;
    xlate("R11", 16'h2102, 2'b00, 1);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule